// File: doc/BRIEF.md
# Dual Timer/Counter with Shared Prescaler

The block contains two 16-bit count channels that share a single clock divider. Each channel counts in one of two ways. As a timer it counts system clocks, either directly or through the divider. As a counter it counts falling edges seen on its own input pin. A per-channel mode field organises the 16 bits in one of four ways: a 13-bit counter, a full 16-bit counter, an 8-bit counter that reloads itself from the upper byte, or two independent 8-bit counters. Channel 0 can run as two 8-bit counters. Its upper byte then takes over channel 1's run bit, overflow flag and toggle output. A channel put in that mode itself only holds its value.

A single-cycle register write port loads the configuration, the run bits, the flags and the four count bytes. The divider setting, the fast/compatibility select and the per-channel divider-apply bits are plain level inputs. In compatibility mode the divider always paces both timers and the pin sampling. In fast mode a channel counts every clock unless its divider-apply bit is set. The pins are assumed synchronous to `clk`. The count registers are brought out for observation, next to the sticky overflow flags and the toggle outputs.

Top module: `tmr_pair`

## Requirements
- R1: After reset both counts are 0, both channels are stopped in 13-bit timer mode with gating off, and `ovf_flag` and `tgl_out` are 0.
- R2: A write with `wr_en` high takes effect at the next clock edge. Address 0 holds the configuration: channel n uses bits [4n+3:4n], with mode in [1:0] (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split), counter select in [2] and gate enable in [3]. Address 1 holds the run bits (bit n). Addresses 2/3 are the low/high count bytes of channel 0, and 4/5 are those of channel 1. Address 6 holds the flags (bit n). A count-byte write overrides counting of that byte in the same cycle.
- R3: In compatibility mode (`compat_mode`=1) a running timer advances exactly once every `presc_div`+1 clocks, whatever `psc_apply` is set to.
- R4: In fast mode a running timer advances every clock when its `psc_apply` bit is 0, and once every `presc_div`+1 clocks when it is 1.
- R5: In fast mode a counter-select channel samples its pin on every clock. It counts once when a high sample is followed by a low one. The new value is visible in the cycle after the clock at which the low sample is taken, so two counts never fall on consecutive clocks.
- R6: In compatibility mode the pin is sampled only on divider ticks. A low pulse that covers no tick is not counted, and a low level present at a tick that follows a high sample is counted.
- R7: A channel advances only when its run bit is 1 and either its gate enable is 0 or its `gate_pin` is high.
- R8: In 13-bit mode bits [4:0] of the low byte form a divide-by-32 stage that carries into the high byte. Low-byte bits [7:5] hold their value. An overflow is signalled when the high byte and low bits [4:0] are all ones and a step occurs.
- R9: In 16-bit mode the count wraps from 0xFFFF to 0x0000 and signals an overflow.
- R10: In 8-bit reload mode the low byte counts. When it is 0xFF, a step loads it from the high byte and signals an overflow.
- R11: With channel 0 in split mode, its low byte is an 8-bit counter under channel 0's own control and flag. Its high byte is an 8-bit timer that runs when run bit 1 is set, and its wrap drives flag 1 and toggle 1. Channel 1's own overflows then affect neither flag 1 nor toggle 1. A channel 1 in split mode holds its count.
- R12: An overflow event sets its `ovf_flag` bit, which stays set until written. A write to address 6 loads the flags, and an overflow in the same cycle still sets its bit.
- R13: Each overflow event inverts the matching `tgl_out` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | BW | Register write data |
| presc_div | input | PSC_W | Divider setting; ratio is value + 1 |
| compat_mode | input | 1 | 1 = compatibility mode, 0 = fast mode |
| psc_apply | input | 2 | Per-channel divider apply in fast mode |
| cnt_pin | input | 2 | External count inputs, one per channel |
| gate_pin | input | 2 | External gate inputs, one per channel |
| ch0_count | output | 2*BW | Channel 0 count {high, low} |
| ch1_count | output | 2*BW | Channel 1 count {high, low} |
| ovf_flag | output | 2 | Sticky overflow flags |
| tgl_out | output | 2 | Overflow toggle outputs |

## Verification
The hardest case to reach is compatibility-mode pin sampling. Whether a short low pulse counts depends on where the free-running divider phase sits, and that phase is not visible at the ports. The stimulus recovers the phase by running channel 1 as a compatibility-mode timer, whose increments mark the divider ticks. It then places a one-clock low pulse between two ticks, where it must be ignored, and a second one across the next tick, where it must count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_BYTE_W = 8;
  localparam int TMR_PSC_W  = 4;
  localparam int TMR_ADDR_W = 3;
  localparam int TMR_LOW13  = 5;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate_en;
    logic      cnt_sel;
    tmr_mode_e mode;
  } ch_cfg_t;

  localparam int CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] phase_q;

  // >= keeps the divider sane when the setting drops below the phase
  assign tick = (phase_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= '0;
    else           phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tmr_pin_sampler.sv
module tmr_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic pin,
  output logic fall
);
  logic last_q;

  // a high sample followed by a low sample
  assign fall = sample_en & last_q & ~pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_q <= 1'b0;
    else if (sample_en) last_q <= pin;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int BW        = 8,
  parameter int LOW13_W   = 5,
  parameter bit HAS_SPLIT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_mode_e     mode,
  input  logic          step_main,
  input  logic          step_hi,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wr_data,
  output logic [BW-1:0] lo_q,
  output logic [BW-1:0] hi_q,
  output logic          ovf_main,
  output logic          ovf_hi
);
  logic [BW-1:0] lo_d, hi_d;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_main = 1'b0;
    ovf_hi   = 1'b0;
    unique case (mode)
      MODE_13: if (step_main) begin
        lo_d[LOW13_W-1:0] = lo_q[LOW13_W-1:0] + 1'b1;
        if (&lo_q[LOW13_W-1:0]) begin
          hi_d     = hi_q + 1'b1;
          ovf_main = &hi_q;
        end
      end
      MODE_16: if (step_main) begin
        {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
        ovf_main     = &{hi_q, lo_q};
      end
      MODE_RELOAD: if (step_main) begin
        if (&lo_q) begin
          lo_d     = hi_q;
          ovf_main = 1'b1;
        end else begin
          lo_d = lo_q + 1'b1;
        end
      end
      MODE_SPLIT: if (HAS_SPLIT) begin
        if (step_main) begin
          lo_d     = lo_q + 1'b1;
          ovf_main = &lo_q;
        end
        if (step_hi) begin
          hi_d   = hi_q + 1'b1;
          ovf_hi = &hi_q;
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_d = wr_data;
    if (wr_hi) hi_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int PSC_W   = TMR_PSC_W,
  parameter int BW      = TMR_BYTE_W,
  parameter int ADDR_W  = TMR_ADDR_W,
  parameter int LOW13_W = TMR_LOW13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BW-1:0]   wr_data,
  input  logic [PSC_W-1:0] presc_div,
  input  logic            compat_mode,
  input  logic [1:0]      psc_apply,
  input  logic [1:0]      cnt_pin,
  input  logic [1:0]      gate_pin,
  output logic [2*BW-1:0] ch0_count,
  output logic [2*BW-1:0] ch1_count,
  output logic [1:0]      ovf_flag,
  output logic [1:0]      tgl_out
);
  localparam int NCH      = 2;
  localparam int CNT_BASE = 2;
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(CNT_BASE + 2*NCH);

  ch_cfg_t        cfg_q   [NCH];
  tmr_mode_e      ch_mode [NCH];
  logic [BW-1:0]  lo_q    [NCH];
  logic [BW-1:0]  hi_q    [NCH];
  logic [NCH-1:0] run_q, flag_q, tgl_q;
  logic [NCH-1:0] run_ok, timer_step, fall, step, step_hi;
  logic [NCH-1:0] wr_lo, wr_hi, ovf_main, ovf_hi, ev;
  logic           tick, sample_en, split0;

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (presc_div),
    .tick (tick)
  );

  assign sample_en = compat_mode ? tick : 1'b1;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_mode[g]    = cfg_q[g].mode;
    assign run_ok[g]     = run_q[g] & (~cfg_q[g].gate_en | gate_pin[g]);
    assign timer_step[g] = (compat_mode | psc_apply[g]) ? tick : 1'b1;
    assign step[g]       = run_ok[g] & (cfg_q[g].cnt_sel ? fall[g] : timer_step[g]);
    assign wr_lo[g]      = wr_en && (wr_addr == ADDR_W'(CNT_BASE + 2*g));
    assign wr_hi[g]      = wr_en && (wr_addr == ADDR_W'(CNT_BASE + 2*g + 1));

    if (g == 0) begin : g_hi_src
      assign step_hi[g] = run_q[NCH-1] & timer_step[0];
    end else begin : g_hi_none
      assign step_hi[g] = 1'b0;
    end

    tmr_pin_sampler u_smp (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_en(sample_en),
      .pin      (cnt_pin[g]),
      .fall     (fall[g])
    );

    tmr_channel #(
      .BW       (BW),
      .LOW13_W  (LOW13_W),
      .HAS_SPLIT(g == 0)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (ch_mode[g]),
      .step_main(step[g]),
      .step_hi  (step_hi[g]),
      .wr_lo    (wr_lo[g]),
      .wr_hi    (wr_hi[g]),
      .wr_data  (wr_data),
      .lo_q     (lo_q[g]),
      .hi_q     (hi_q[g]),
      .ovf_main (ovf_main[g]),
      .ovf_hi   (ovf_hi[g])
    );
  end

  assign split0 = (cfg_q[0].mode == MODE_SPLIT);
  assign ev[0]  = ovf_main[0];
  assign ev[1]  = split0 ? ovf_hi[0] : ovf_main[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) cfg_q[i] <= '{gate_en: 1'b0, cnt_sel: 1'b0, mode: MODE_13};
      run_q  <= '0;
      flag_q <= '0;
      tgl_q  <= '0;
    end else begin
      if (wr_en && wr_addr == A_CFG)
        for (int i = 0; i < NCH; i++) cfg_q[i] <= ch_cfg_t'(wr_data[CFG_W*i +: CFG_W]);
      if (wr_en && wr_addr == A_RUN) run_q <= wr_data[NCH-1:0];
      if (wr_en && wr_addr == A_FLAG) flag_q <= wr_data[NCH-1:0] | ev;
      else                            flag_q <= flag_q | ev;
      tgl_q <= tgl_q ^ ev;
    end
  end

  assign ch0_count = {hi_q[0], lo_q[0]};
  assign ch1_count = {hi_q[1], lo_q[1]};
  assign ovf_flag  = flag_q;
  assign tgl_out   = tgl_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
#(
  parameter int BW     = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              compat_mode,
  input logic [1:0]        mode0,
  input logic [1:0]        mode1,
  input logic              cnt_sel0,
  input logic              run0,
  input logic              step0,
  input logic [2*BW-1:0]   ch0_count,
  input logic [2*BW-1:0]   ch1_count,
  input logic [1:0]        ovf_flag,
  input logic [1:0]        tgl_out
);
  logic wr_ch0, wr_ch1;
  assign wr_ch0 = wr_en && (wr_addr == ADDR_W'(2) || wr_addr == ADDR_W'(3));
  assign wr_ch1 = wr_en && (wr_addr == ADDR_W'(4) || wr_addr == ADDR_W'(5));

  // R7
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && mode0 != MODE_SPLIT && !wr_ch0) |=> $stable(ch0_count));

  // R11
  split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 == MODE_SPLIT && !wr_ch1) |=> $stable(ch1_count));

  // R5
  fast_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!compat_mode && cnt_sel0 && mode0 == MODE_16 && !wr_ch0 &&
     $past(!compat_mode && cnt_sel0 && mode0 == MODE_16 && !wr_ch0) &&
     !$stable(ch0_count)) |=> $stable(ch0_count));

  // R10
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == MODE_RELOAD && step0 && ch0_count[BW-1:0] == {BW{1'b1}} && !wr_ch0)
    |=> ch0_count[BW-1:0] == $past(ch0_count[2*BW-1:BW]));

  // R13
  tgl0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tgl_out[0]) |-> ovf_flag[0]);

  // R13
  tgl1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tgl_out[1]) |-> ovf_flag[1]);
endmodule

bind tmr_pair tmr_pair_chk #(.BW(BW), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .compat_mode(compat_mode),
  .mode0      (ch_mode[0]),
  .mode1      (ch_mode[1]),
  .cnt_sel0   (cfg_q[0].cnt_sel),
  .run0       (run_q[0]),
  .step0      (step[0]),
  .ch0_count  (ch0_count),
  .ch1_count  (ch1_count),
  .ovf_flag   (ovf_flag),
  .tgl_out    (tgl_out)
);

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  presc_div = '0;
  logic        compat_mode = 1'b0;
  logic [1:0]  psc_apply = '0;
  logic [1:0]  cnt_pin = 2'b11;
  logic [1:0]  gate_pin = 2'b00;
  logic [15:0] ch0_count, ch1_count;
  logic [1:0]  ovf_flag, tgl_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_pair u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .presc_div(presc_div), .compat_mode(compat_mode), .psc_apply(psc_apply),
    .cnt_pin(cnt_pin), .gate_pin(gate_pin), .ch0_count(ch0_count),
    .ch1_count(ch1_count), .ovf_flag(ovf_flag), .tgl_out(tgl_out)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] init;
    logic [7:0]  n;
    logic [15:0] expv;
    logic        ovf;
  } vec_t;

  // channel 0 timer, fast mode, no divider: mode, start, steps, result, overflow
  localparam vec_t VECS [8] = '{
    '{2'd1, 16'h0000, 8'd10, 16'h000A, 1'b0},  // R9
    '{2'd1, 16'hFFFE, 8'd3,  16'h0001, 1'b1},  // R9 wrap
    '{2'd0, 16'h121E, 8'd3,  16'h1301, 1'b0},  // R8 carry
    '{2'd0, 16'hFFFF, 8'd1,  16'h00E0, 1'b1},  // R8 wrap, bits 7:5 held
    '{2'd2, 16'hF0FE, 8'd4,  16'hF0F2, 1'b1},  // R10 reload
    '{2'd2, 16'h8000, 8'd5,  16'h8005, 1'b0},  // R10
    '{2'd1, 16'h7FFF, 8'd1,  16'h8000, 1'b0},  // R9 byte carry
    '{2'd3, 16'h55FD, 8'd4,  16'h5501, 1'b1}   // R11 low byte alone
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // clocks between two successive changes of channel 0
  task automatic gap0(output int gap);
    logic [15:0] prev;
    prev = ch0_count;
    for (int k = 0; k < 40 && ch0_count == prev; k++) @(negedge clk);
    prev = ch0_count;
    gap = 0;
    for (int k = 0; k < 40 && ch0_count == prev; k++) begin
      @(negedge clk);
      gap++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g;
    logic [15:0] c;
    logic t0, t1;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 ch0", ch0_count, 0);
    chk("R1 ch1", ch1_count, 0);
    chk("R1 flags/tgl", {ovf_flag, tgl_out}, 0);

    for (int i = 0; i < 8; i++) begin
      wr(3'd0, {4'b0001, 2'b00, VECS[i].mode});
      wr(3'd2, VECS[i].init[7:0]);
      wr(3'd3, VECS[i].init[15:8]);
      wr(3'd6, 8'h00);
      t0 = tgl_out[0];
      wr(3'd1, 8'h01);
      idle(VECS[i].n - 1);
      wr(3'd1, 8'h00);
      chk("R8/R9/R10/R11 vector count", ch0_count, VECS[i].expv);
      chk("R12 vector flag", ovf_flag[0], VECS[i].ovf);
      chk("R13 vector toggle", tgl_out[0] ^ t0, VECS[i].ovf);
    end

    // R2 write overrides counting
    wr(3'd0, 8'h11);
    wr(3'd1, 8'h01);
    idle(3);
    wr(3'd2, 8'h40);
    chk("R2 override", ch0_count[7:0], 8'h40);
    idle(1);
    chk("R2 resumes", ch0_count[7:0], 8'h41);
    wr(3'd1, 8'h00);

    // R3 compatibility divider
    compat_mode = 1'b1; presc_div = 4'd5;
    wr(3'd1, 8'h01);
    gap0(g); gap0(g);
    chk("R3 div 6", g, 6);
    psc_apply = 2'b01;
    gap0(g);
    chk("R3 psc_apply ignored", g, 6);
    psc_apply = 2'b00; presc_div = 4'd2;
    gap0(g); gap0(g);
    chk("R3 div 3", g, 3);
    // R4 fast mode
    compat_mode = 1'b0; presc_div = 4'd3;
    gap0(g); gap0(g);
    chk("R4 undivided", g, 1);
    psc_apply = 2'b01;
    gap0(g); gap0(g);
    chk("R4 divided", g, 4);
    psc_apply = 2'b00;
    wr(3'd1, 8'h00);

    // R5 fast counter
    wr(3'd0, 8'h15);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h01);
    idle(2);
    cnt_pin[0] = 1'b0;
    chk("R5 before edge", ch0_count, 0);
    idle(1);
    chk("R5 one cycle later", ch0_count, 1);
    for (int k = 0; k < 2; k++) begin
      cnt_pin[0] = 1'b1; idle(1);
      cnt_pin[0] = 1'b0; idle(1);
    end
    cnt_pin[0] = 1'b1; idle(1);
    chk("R5 half-rate pulses", ch0_count, 3);

    // R6 compatibility sampling, phase found from channel 1 timer
    compat_mode = 1'b1; presc_div = 4'd5;
    wr(3'd1, 8'h03);
    idle(14);
    c = ch1_count;
    for (int k = 0; k < 20 && ch1_count == c; k++) @(negedge clk);
    c = ch0_count;
    cnt_pin[0] = 1'b0; idle(1);
    cnt_pin[0] = 1'b1;
    chk("R6 pulse between ticks ignored", ch0_count, c);
    idle(4);
    cnt_pin[0] = 1'b0; idle(1);
    cnt_pin[0] = 1'b1;
    chk("R6 pulse on tick counted", ch0_count, c + 16'd1);
    wr(3'd1, 8'h00);
    compat_mode = 1'b0;

    // R7 gating
    wr(3'd0, 8'h19);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h01);
    idle(5);
    chk("R7 gate low halts", ch0_count, 0);
    gate_pin[0] = 1'b1; idle(4);
    gate_pin[0] = 1'b0;
    chk("R7 gate high runs", ch0_count, 4);
    idle(3);
    chk("R7 halts again", ch0_count, 4);
    wr(3'd1, 8'h00);

    // R11 split high byte under run bit 1
    wr(3'd0, 8'h33);
    wr(3'd2, 8'h10); wr(3'd3, 8'hFE);
    wr(3'd4, 8'h77); wr(3'd5, 8'h66);
    wr(3'd6, 8'h00);
    t1 = tgl_out[1];
    wr(3'd1, 8'h02);
    idle(1);
    wr(3'd1, 8'h00);
    chk("R11 high byte wraps", ch0_count, 16'h0010);
    chk("R11 flag 1", ovf_flag, 2'b10);
    chk("R11 toggle 1", tgl_out[1] ^ t1, 1);
    chk("R11 split channel 1 holds", ch1_count, 16'h6677);

    // R11 channel 1 overflow suppressed while channel 0 is split
    wr(3'd0, 8'h13);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd6, 8'h00);
    t1 = tgl_out[1];
    wr(3'd1, 8'h02);
    wr(3'd1, 8'h00);
    chk("R11 channel 1 wrapped", ch1_count, 16'h0000);
    chk("R11 no flag from channel 1", {ovf_flag[1], tgl_out[1] ^ t1}, 2'b00);

    // R12 flag writes
    wr(3'd6, 8'h03);
    chk("R12 flags set by write", ovf_flag, 2'b11);
    wr(3'd6, 8'h00);
    chk("R12 flags cleared by write", ovf_flag, 2'b00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule